// File: doc/BRIEF.md
# I2C Target with 10-bit Addressing

This block is a bus target for I2C that answers to a single 10-bit address. It watches SCL and SDA through synchronisers clocked by the system clock. It pulls SDA low through an output enable and never drives it high. A controller addresses it with a two-byte header. The first byte is a fixed code followed by the two upper address bits and the direction bit. The second byte holds the lower eight address bits. Every data byte that follows is presented on a byte-wide write strobe.

The block supports the combined format. After a full write-direction match, the controller may issue a repeated START and send only the first header byte with the direction bit set. The target then switches to transmitting. It requests each outgoing byte through a one-cycle fetch strobe and shifts the byte out MSB first. A STOP ends the transaction and forgets the match. A later read request then needs the full write header again first.

Top module: `i2c_tenbit_target`

## Requirements
- R1: While reset is held and after it is released with an idle bus, `sda_oe_o`, `wr_valid_o` and `rd_req_o` are all low.
- R2: SDA falling while SCL is high is a START and begins a new header byte from any state, including directly after an acknowledge clock. SDA rising while SCL is high is a STOP: it releases SDA and clears any address match.
- R3: The first header byte is judged as follows. Bits 7:3 must equal 11110. Bits 2:1 must equal address bits 9:8. Bit 0 is the direction, where 0 means write. With direction 0, the byte is acknowledged (SDA pulled low for the whole ninth clock) only when both fields match. Otherwise SDA stays released, and the target ignores the bus until the next START or STOP.
- R4: After an acknowledged write header byte, the second byte is acknowledged only when it equals address bits 7:0. That completes the match and enters write mode. A mismatch is not acknowledged, and no later byte is acknowledged or written.
- R5: In write mode, data bits are taken MSB first and every byte is acknowledged. Each byte produces a one-cycle `wr_valid_o` pulse with the byte on `wr_data_o`.
- R6: After a full match and without an intervening STOP, a repeated START followed by a first header byte with matching fields and direction 1 is acknowledged and enters read mode.
- R7: In read mode, `rd_req_o` pulses for one cycle. On that clock edge `rd_data_i` is captured. The byte is sent MSB first. A controller acknowledge fetches the next byte the same way.
- R8: A controller not-acknowledge ends the read. SDA stays released and no further byte is fetched until the next START.
- R9: A first header byte with direction 1 is not acknowledged when no full match has been made since the last STOP. In that case no byte is fetched.
- R10: The target changes its SDA output enable only while the synchronised SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_data_o | output | 8 | Received data byte, valid with `wr_valid_o` |
| rd_req_o | output | 1 | One-cycle strobe; `rd_data_i` is captured on this edge |
| rd_data_i | input | 8 | Byte to transmit in read mode |

## Verification
A wrong bit count or a wrong state shows up first on SDA during the next ninth clock. The acknowledge either appears when it should not or is missing. The controller's own sampling of that clock exposes the fault within one byte. A lost or stale address match shows on the following header byte as a wrong acknowledge or an unexpected fetch strobe. A wrong read shifter shows as a wrong bit within the same byte. A read that fails to end shows as a pulled-low bit or an extra `rd_req_o` pulse in the byte clocked after the not-acknowledge.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    // bit counter values: ninth clock (acknowledge) and end of byte
    localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W + 1);

    localparam logic [4:0] HDR_CODE = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADH  = 3'd1,
        ST_ADL  = 3'd2,
        ST_WR   = 3'd3,
        ST_RD   = 3'd4,
        ST_SKIP = 3'd5
    } t10_state_e;

    typedef struct packed {
        t10_state_e        state;
        t10_state_e        pend;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              oe;
        logic              matched;
        logic              mnack;
        logic              wr_pulse;
        logic [BYTE_W-1:0] wr_data;
        logic              rd_pulse;
    } t10_regs_t;

endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '1;
                else        stg_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '1;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/i2c10_cond.sv
module i2c10_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign start_ev = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_ev  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
    assign scl_rise = scl_s & ~prev_q.scl;
    assign scl_fall = ~scl_s & prev_q.scl;
endmodule

// File: rtl/i2c10_engine.sv
module i2c10_engine
    import i2c10_pkg::*;
#(
    parameter logic [9:0] TARGET_ADDR = 10'h2B6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o
);
    t10_regs_t  d, q;
    logic       hdr_ok, lo_ok, ack_w;
    t10_state_e nxt_w;

    // verdict on the byte just received, used on the fall ending bit 8
    always_comb begin
        hdr_ok = (q.rx[7:3] == HDR_CODE) && (q.rx[2:1] == TARGET_ADDR[9:8]);
        lo_ok  = (q.rx == TARGET_ADDR[7:0]);
        ack_w  = 1'b0;
        nxt_w  = ST_SKIP;
        case (q.state)
            ST_ADH: begin
                if (!q.rx[0]) begin
                    ack_w = hdr_ok;
                    nxt_w = hdr_ok ? ST_ADL : ST_SKIP;
                end else begin
                    ack_w = hdr_ok && q.matched;
                    nxt_w = (hdr_ok && q.matched) ? ST_RD : ST_SKIP;
                end
            end
            ST_ADL: begin
                ack_w = lo_ok;
                nxt_w = lo_ok ? ST_WR : ST_SKIP;
            end
            ST_WR: begin
                ack_w = 1'b1;
                nxt_w = ST_WR;
            end
            default: begin
                ack_w = 1'b0;
                nxt_w = ST_SKIP;
            end
        endcase
    end

    always_comb begin
        d          = q;
        d.wr_pulse = 1'b0;
        d.rd_pulse = 1'b0;
        if (stop_ev) begin
            d.state   = ST_IDLE;
            d.cnt     = '0;
            d.oe      = 1'b0;
            d.matched = 1'b0;
        end else if (start_ev) begin
            d.state = ST_ADH;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else if (q.state != ST_IDLE && q.state != ST_SKIP) begin
            if (scl_rise) begin
                if (q.cnt < CNT_ACK) d.rx = {q.rx[BYTE_W-2:0], sda_s};
                if (q.cnt == CNT_ACK) d.mnack = sda_s;
                d.cnt = q.cnt + 1'b1;
            end else if (scl_fall) begin
                if (q.state == ST_RD) begin
                    if (q.cnt != '0 && q.cnt < CNT_ACK) begin
                        d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                        d.oe = ~q.tx[BYTE_W-2];
                    end else if (q.cnt == CNT_ACK) begin
                        d.oe = 1'b0;
                    end else if (q.cnt == CNT_END) begin
                        d.cnt = '0;
                        if (q.mnack) begin
                            d.state = ST_SKIP;
                            d.oe    = 1'b0;
                        end else begin
                            d.tx       = rd_data_i;
                            d.oe       = ~rd_data_i[BYTE_W-1];
                            d.rd_pulse = 1'b1;
                        end
                    end
                end else begin
                    if (q.cnt == CNT_ACK) begin
                        d.oe   = ack_w;
                        d.pend = nxt_w;
                        if (q.state == ST_ADH && !q.rx[0]) d.matched = 1'b0;
                        if (q.state == ST_ADL) d.matched = lo_ok;
                        if (q.state == ST_WR) begin
                            d.wr_pulse = 1'b1;
                            d.wr_data  = q.rx;
                        end
                    end else if (q.cnt == CNT_END) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.state = q.pend;
                        if (q.pend == ST_RD) begin
                            d.tx       = rd_data_i;
                            d.oe       = ~rd_data_i[BYTE_W-1];
                            d.rd_pulse = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o   = q.oe;
    assign wr_valid_o = q.wr_pulse;
    assign wr_data_o  = q.wr_data;
    assign rd_req_o   = q.rd_pulse;
endmodule

// File: rtl/i2c_tenbit_target.sv
module i2c_tenbit_target
    import i2c10_pkg::*;
#(
    parameter logic [9:0] TARGET_ADDR = 10'h2B6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    input  logic [BYTE_W-1:0] rd_data_i
);
    logic [1:0] pins_s;
    logic       scl_s, sda_s;
    logic       start_w, stop_w, rise_w, fall_w;

    i2c10_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (pins_s)
    );

    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2c10_cond cond_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_ev(start_w),
        .stop_ev (stop_w),
        .scl_rise(rise_w),
        .scl_fall(fall_w)
    );

    i2c10_engine #(.TARGET_ADDR(TARGET_ADDR)) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ev  (start_w),
        .stop_ev   (stop_w),
        .scl_rise  (rise_w),
        .scl_fall  (fall_w),
        .sda_s     (sda_s),
        .rd_data_i (rd_data_i),
        .sda_oe_o  (sda_oe_o),
        .wr_valid_o(wr_valid_o),
        .wr_data_o (wr_data_o),
        .rd_req_o  (rd_req_o)
    );
endmodule

// File: rtl/i2c10_checker.sv
module i2c10_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_w,
    input logic stop_w,
    input logic sda_oe_o,
    input logic wr_valid_o,
    input logic rd_req_o
);
    // R10: output enable moves only while the sampled clock line was low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe_o != $past(sda_oe_o)) && !$past(start_w) && !$past(stop_w))
        |-> !$past(scl_s));

    // R2: a STOP releases SDA on the next cycle
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> !sda_oe_o);

    // R2: a START releases SDA on the next cycle
    p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> !sda_oe_o);

    // R5: write strobe lasts one cycle
    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R7: fetch strobe lasts one cycle
    p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R5 and R7: a direction is fixed per phase, never both strobes at once
    p_dir_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_o && rd_req_o));
endmodule

bind i2c_tenbit_target i2c10_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_w   (start_w),
    .stop_w    (stop_w),
    .sda_oe_o  (sda_oe_o),
    .wr_valid_o(wr_valid_o),
    .rd_req_o  (rd_req_o)
);

// File: tb/i2c_tenbit_target_tb_top.sv
module i2c_tenbit_target_tb_top;
    localparam int         CLK_PERIOD = 10;
    localparam int         QTR        = 10;
    localparam logic [9:0] ADDR       = 10'h2B6;
    localparam logic [7:0] HDR_W      = {5'b11110, ADDR[9:8], 1'b0};
    localparam logic [7:0] HDR_R      = {5'b11110, ADDR[9:8], 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, wr_valid, rd_req;
    logic [7:0] wr_data, rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    int rd_cnt  = 0;
    logic [7:0] wr_log [16];

    assign sda_line = sda_m & ~sda_oe;

    i2c_tenbit_target #(.TARGET_ADDR(ADDR)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .wr_valid_o(wr_valid),
        .wr_data_o (wr_data),
        .rd_req_o  (rd_req),
        .rd_data_i (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rd_val(int k);
        return 8'h5A + 8'(k) * 8'h33;
    endfunction

    assign rd_data = rd_val(rd_cnt);

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                wr_log[wr_cnt[3:0]] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (rd_req) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(2*QTR);
        sda_m = 1'b0; wq(2*QTR);
        scl_m = 1'b0; wq(QTR);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(QTR);
        scl_m = 1'b1; wq(2*QTR);
        sda_m = 1'b0; wq(2*QTR);
        scl_m = 1'b0; wq(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(QTR);
        scl_m = 1'b1; wq(2*QTR);
        sda_m = 1'b1; wq(2*QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(QTR);
            scl_m = 1'b1; wq(2*QTR);
            scl_m = 1'b0; wq(QTR);
        end
        sda_m = 1'b1; wq(QTR);
        scl_m = 1'b1; wq(QTR);
        acked = !sda_line;
        wq(QTR);
        scl_m = 1'b0; wq(QTR);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit steady);
        logic first;
        steady = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(QTR);
            scl_m = 1'b1; wq(1);
            first = sda_line;
            wq(QTR - 1);
            b[i] = sda_line;
            wq(QTR - 1);
            if (sda_line != first) steady = 1'b0;
            wq(1);
            scl_m = 1'b0; wq(QTR);
        end
        sda_m = !give_ack; wq(QTR);
        scl_m = 1'b1; wq(2*QTR);
        scl_m = 1'b0; wq(QTR);
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        wq(5);
        chk("R1", "oe in reset", int'(sda_oe), 0);
        chk("R1", "wr strobe in reset", int'(wr_valid), 0);
        rst_n = 1'b1;
        wq(10);
        chk("R1", "oe after reset", int'(sda_oe), 0);
        chk("R1", "fetch strobe after reset", int'(rd_req), 0);
    endtask

    task automatic t_write();
        bit a;
        int w0 = wr_cnt;
        bus_start();
        send_byte(HDR_W, a); chk("R3", "ack header write", int'(a), 1);
        send_byte(ADDR[7:0], a); chk("R4", "ack low address", int'(a), 1);
        send_byte(8'h3C, a); chk("R5", "ack data 1", int'(a), 1);
        send_byte(8'hC3, a); chk("R5", "ack data 2", int'(a), 1);
        bus_stop();
        wq(4);
        chk("R5", "write count", wr_cnt - w0, 2);
        chk("R5", "write byte 1", int'(wr_log[w0[3:0]]), 8'h3C);
        chk("R5", "write byte 2", int'(wr_log[4'(w0 + 1)]), 8'hC3);
        chk("R2", "released after stop", int'(sda_oe), 0);
    endtask

    task automatic t_bad_upper();
        bit a;
        int w0 = wr_cnt;
        bus_start();
        send_byte({5'b11110, ~ADDR[9:8], 1'b0}, a); chk("R3", "nack wrong A9:A8", int'(a), 0);
        send_byte(ADDR[7:0], a); chk("R3", "ignored after nack", int'(a), 0);
        send_byte(8'h55, a); chk("R3", "data ignored", int'(a), 0);
        bus_stop();
        chk("R3", "no write after nack", wr_cnt - w0, 0);
    endtask

    task automatic t_bad_code();
        bit a;
        bus_start();
        send_byte({5'b11100, ADDR[9:8], 1'b0}, a); chk("R3", "nack wrong code", int'(a), 0);
        bus_stop();
    endtask

    task automatic t_bad_lower();
        bit a;
        int w0 = wr_cnt;
        bus_start();
        send_byte(HDR_W, a); chk("R3", "ack header", int'(a), 1);
        send_byte(ADDR[7:0] ^ 8'h01, a); chk("R4", "nack wrong low byte", int'(a), 0);
        send_byte(8'h99, a); chk("R4", "data not acked", int'(a), 0);
        bus_stop();
        chk("R4", "no write after low miss", wr_cnt - w0, 0);
    endtask

    task automatic t_combined();
        bit a, st;
        logic [7:0] b;
        int w0 = wr_cnt;
        int r0;
        bus_start();
        send_byte(HDR_W, a);
        send_byte(ADDR[7:0], a);
        send_byte(8'h81, a); chk("R5", "ack data before Sr", int'(a), 1);
        r0 = rd_cnt;
        bus_rstart();
        send_byte(HDR_R, a); chk("R6", "ack read header after Sr", int'(a), 1);
        recv_byte(1'b1, b, st);
        chk("R7", "read byte 1", int'(b), int'(rd_val(r0)));
        chk("R10", "SDA steady while SCL high", int'(st), 1);
        recv_byte(1'b0, b, st);
        chk("R7", "read byte 2", int'(b), int'(rd_val(r0 + 1)));
        chk("R7", "fetch count", rd_cnt - r0, 2);
        recv_byte(1'b0, b, st);
        chk("R8", "line released after nack", int'(b), 8'hFF);
        chk("R8", "no fetch after nack", rd_cnt - r0, 2);
        bus_stop();
        chk("R5", "write before Sr", wr_cnt - w0, 1);
        chk("R5", "write byte before Sr", int'(wr_log[w0[3:0]]), 8'h81);
    endtask

    task automatic t_read_unmatched();
        bit a, st;
        logic [7:0] b;
        int r0 = rd_cnt;
        bus_start();
        send_byte(HDR_R, a); chk("R9", "nack read without match", int'(a), 0);
        recv_byte(1'b0, b, st);
        chk("R9", "line idle", int'(b), 8'hFF);
        chk("R9", "no fetch", rd_cnt - r0, 0);
        bus_stop();
    endtask

    task automatic t_restart_write();
        bit a;
        int w0 = wr_cnt;
        bus_start();
        send_byte(HDR_W, a);
        send_byte(ADDR[7:0], a);
        send_byte(8'h11, a);
        bus_rstart();
        send_byte(HDR_W, a); chk("R2", "header acked after Sr", int'(a), 1);
        send_byte(ADDR[7:0], a); chk("R2", "low byte acked after Sr", int'(a), 1);
        send_byte(8'h22, a);
        bus_stop();
        chk("R2", "writes across Sr", wr_cnt - w0, 2);
        chk("R2", "second write value", int'(wr_log[4'(w0 + 1)]), 8'h22);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_bad_upper();
        t_bad_code();
        t_bad_lower();
        t_combined();
        t_read_unmatched();
        t_restart_write();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule